// File: doc/BRIEF.md
# Multiplexed Bus Master Controller

This block is the bus-master sequencer for a 16-bit bus on which the address and the data share the same wires at different times. A core-side client asks for a transfer by raising a request together with the address, the write data and three attribute flags: direction, memory or I/O space, and data or instruction fetch. The controller then wins the bus from an external arbiter and runs one bus cycle. It pulses a completion flag, and on a read it returns the captured data.

A bus cycle has an address phase and a data phase. The address phase opens with a one-clock address strobe, and the slave latches the address on the falling edge of that strobe. Each phase can be stretched independently by its own ready input. Every pad the block can float has its own output-enable, so the pads can sit in high impedance whenever this master does not own the bus. A lock flag on a request keeps the shared lock line low after that cycle, so the next cycle follows at once without rearbitration. This is how read-modify-write pairs are built.

Top module: `mbus_master`

## Requirements
- R1: While reset is low, the request output is high (inactive), the address strobe is low, the data strobe is high (inactive), done is low and every output-enable (bus, strobes, status, busy, lock) is low. This holds even when reset arrives in the middle of a cycle.
- R2: One clock after a request is seen while the master is idle, the request output goes low. The bus is taken only on a clock where grant is low, busy-in is high and lock-in is high; the address strobe rises in the next clock and the request output returns high in that same clock.
- R3: With both ready inputs high, a cycle lasts four clocks counted from the address-strobe clock, and done is high only in the fourth clock. In that clock busy is driven high.
- R4: The address strobe is high for exactly one clock, the first clock of the cycle. Throughout the address phase the bus carries the request address with its output-enable high.
- R5: After the strobe clock, the address phase holds for one clock plus one more for every clock in which address-ready is sampled low.
- R6: The data strobe is low for the whole data phase: one clock plus one more for every clock in which data-ready is sampled low. It is never low together with the address strobe.
- R7: On a write, the bus carries the write data during the data phase. On a read, the bus output-enable is low during the data phase, and the read-data output holds the bus input sampled on the clock that ends the data phase with data-ready high.
- R8: During a cycle the status outputs are direction = 1 for read, space = 1 for memory and kind = 1 for data, and the status output-enable is high.
- R9: While the request output is low, none of the bus, strobe or busy output-enables is high.
- R10: In a cycle that is not locked, the lock output follows busy: it is low while busy is low and high in the completion clock.
- R11: After a cycle requested with lock set, the lock output stays low and enabled while idle. The next request then starts its strobe one clock later without lowering the request output, and the lock is released after that next cycle if it was unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Core transfer request, held until done |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMem | input | 1 | 1 = memory space, 0 = I/O space |
| reqData | input | 1 | 1 = data access, 0 = instruction fetch |
| reqLock | input | 1 | Keep the bus locked after this cycle |
| reqAddr | input | 16 | Transfer address |
| reqWdata | input | 16 | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Captured read data |
| busReqN | output | 1 | Bus request to arbiter, active low |
| busGntN | input | 1 | Bus grant from arbiter, active low |
| busyIn | input | 1 | Sensed busy line, low = bus in use |
| busyOut | output | 1 | Driven busy value |
| busyOe | output | 1 | Busy pad output-enable |
| lockIn | input | 1 | Sensed lock line, low = locked |
| lockOut | output | 1 | Driven lock value |
| lockOe | output | 1 | Lock pad output-enable |
| adStrb | output | 1 | Address strobe, active high |
| dStrbN | output | 1 | Data strobe, active low |
| strbOe | output | 1 | Strobe pads output-enable |
| rdyA | input | 1 | Address-phase ready |
| rdyD | input | 1 | Data-phase ready |
| ibIn | input | 16 | Bus value sensed from the pads |
| ibOut | output | 16 | Bus value to drive |
| ibOe | output | 1 | Bus output-enable |
| rdWr | output | 1 | Status: 1 = read |
| memIo | output | 1 | Status: 1 = memory |
| datInst | output | 1 | Status: 1 = data |
| statOe | output | 1 | Status pads output-enable |

## Verification
The bench goes after arbitration: grant, busy and lock are each withheld in turn. A design that ignored any one of them would strobe an address onto a bus another master still owns. Unequal address and data wait counts are mixed across reads and writes, so an implementation that shared one wait counter, or sampled ready in the strobe clock, ends the cycle on the wrong clock. The locked read-modify-write pair checks that the lock line stays low between the two cycles and that no new request is raised. Reset in the middle of a cycle checks that every pad is released at once, not at the end of the cycle.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_ADDR,
    ST_AHOLD,
    ST_DATA,
    ST_DWAIT,
    ST_FIN
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // latch the core request
    logic capture;    // sample read data
    logic driveAddr;  // put address on the bus
    logic driveData;  // put write data on the bus
  } dpCtl_t;

endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   busGntN,
  input  logic   busyIn,
  input  logic   lockIn,
  input  logic   rdyA,
  input  logic   rdyD,
  input  logic   curWrite,
  input  logic   curLock,
  output dpCtl_t dpCtl,
  output logic   busReqN,
  output logic   busyOut,
  output logic   busyOe,
  output logic   lockOut,
  output logic   lockOe,
  output logic   adStrb,
  output logic   dStrbN,
  output logic   strbOe,
  output logic   statOe,
  output logic   done
);

  busState_e state, nextState;
  logic lockHeld;
  logic acquire, inCycle, owned, inData;

  assign acquire = !busGntN && busyIn && lockIn;
  assign inData  = (state == ST_DATA) || (state == ST_DWAIT);
  assign inCycle = (state == ST_ADDR) || (state == ST_AHOLD) || inData;
  assign owned   = inCycle || (state == ST_FIN);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (reqValid) nextState = lockHeld ? ST_ADDR : ST_ARB;
      ST_ARB:   if (acquire) nextState = ST_ADDR;
      ST_ADDR:  nextState = ST_AHOLD;
      ST_AHOLD: if (rdyA) nextState = ST_DATA;
      ST_DATA:  nextState = rdyD ? ST_FIN : ST_DWAIT;
      ST_DWAIT: if (rdyD) nextState = ST_FIN;
      ST_FIN:   nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lockHeld <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_FIN) lockHeld <= curLock;
    end
  end

  always_comb begin
    dpCtl.load      = ((state == ST_IDLE) && reqValid && lockHeld) ||
                      ((state == ST_ARB) && acquire);
    dpCtl.capture   = inData && rdyD && !curWrite;
    dpCtl.driveAddr = (state == ST_ADDR) || (state == ST_AHOLD);
    dpCtl.driveData = inData && curWrite;
  end

  assign busReqN = (state != ST_ARB);
  assign busyOut = !inCycle;
  assign busyOe  = owned;
  assign lockOut = !(inCycle || ((state == ST_FIN) && curLock) || lockHeld);
  assign lockOe  = owned || lockHeld;
  assign adStrb  = (state == ST_ADDR);
  assign dStrbN  = !inData;
  assign strbOe  = owned;
  assign statOe  = owned;
  assign done    = (state == ST_FIN);

endmodule

// File: rtl/mbus_dpath.sv
module mbus_dpath
  import mbus_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtl_t       dpCtl,
  input  logic         reqWrite,
  input  logic         reqMem,
  input  logic         reqData,
  input  logic         reqLock,
  input  logic [W-1:0] reqAddr,
  input  logic [W-1:0] reqWdata,
  input  logic [W-1:0] ibIn,
  output logic [W-1:0] ibOut,
  output logic         ibOe,
  output logic [W-1:0] rdata,
  output logic         curWrite,
  output logic         curLock,
  output logic         rdWr,
  output logic         memIo,
  output logic         datInst
);

  logic [W-1:0] curAddr, curWdata;
  logic curMem, curData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      curWdata <= '0;
      curWrite <= 1'b0;
      curMem   <= 1'b0;
      curData  <= 1'b0;
      curLock  <= 1'b0;
    end else if (dpCtl.load) begin
      curAddr  <= reqAddr;
      curWdata <= reqWdata;
      curWrite <= reqWrite;
      curMem   <= reqMem;
      curData  <= reqData;
      curLock  <= reqLock;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdata <= '0;
    else if (dpCtl.capture) rdata <= ibIn;
  end

  assign ibOut   = dpCtl.driveAddr ? curAddr : curWdata;
  assign ibOe    = dpCtl.driveAddr || dpCtl.driveData;
  assign rdWr    = !curWrite;
  assign memIo   = curMem;
  assign datInst = curData;

endmodule

// File: rtl/mbus_master.sv
module mbus_master
  import mbus_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         reqMem,
  input  logic         reqData,
  input  logic         reqLock,
  input  logic [W-1:0] reqAddr,
  input  logic [W-1:0] reqWdata,
  output logic         done,
  output logic [W-1:0] rdata,
  output logic         busReqN,
  input  logic         busGntN,
  input  logic         busyIn,
  output logic         busyOut,
  output logic         busyOe,
  input  logic         lockIn,
  output logic         lockOut,
  output logic         lockOe,
  output logic         adStrb,
  output logic         dStrbN,
  output logic         strbOe,
  input  logic         rdyA,
  input  logic         rdyD,
  input  logic [W-1:0] ibIn,
  output logic [W-1:0] ibOut,
  output logic         ibOe,
  output logic         rdWr,
  output logic         memIo,
  output logic         datInst,
  output logic         statOe
);

  dpCtl_t dpCtl;
  logic curWrite, curLock;

  mbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .busGntN(busGntN), .busyIn(busyIn), .lockIn(lockIn),
    .rdyA(rdyA), .rdyD(rdyD), .curWrite(curWrite), .curLock(curLock),
    .dpCtl(dpCtl), .busReqN(busReqN), .busyOut(busyOut), .busyOe(busyOe),
    .lockOut(lockOut), .lockOe(lockOe), .adStrb(adStrb), .dStrbN(dStrbN),
    .strbOe(strbOe), .statOe(statOe), .done(done)
  );

  mbus_dpath #(.W(W)) u_dpath (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl),
    .reqWrite(reqWrite), .reqMem(reqMem), .reqData(reqData), .reqLock(reqLock),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ibIn(ibIn),
    .ibOut(ibOut), .ibOe(ibOe), .rdata(rdata),
    .curWrite(curWrite), .curLock(curLock),
    .rdWr(rdWr), .memIo(memIo), .datInst(datInst)
  );

endmodule

// File: rtl/mbus_master_chk.sv
module mbus_master_chk (
  input logic clk,
  input logic rstN,
  input logic busReqN,
  input logic adStrb,
  input logic dStrbN,
  input logic strbOe,
  input logic statOe,
  input logic ibOe,
  input logic busyOut,
  input logic busyOe,
  input logic lockOut,
  input logic lockOe,
  input logic rdWr,
  input logic done
);

  a_r2_req_off: assert property (@(posedge clk) disable iff (!rstN)
    adStrb |-> busReqN);

  a_r3_done_fin: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyOut && busyOe && dStrbN && !adStrb));

  a_r4_strb_one: assert property (@(posedge clk) disable iff (!rstN)
    adStrb |=> !adStrb);

  a_r4_strb_drive: assert property (@(posedge clk) disable iff (!rstN)
    adStrb |-> (ibOe && strbOe && statOe));

  a_r6_strb_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(adStrb && !dStrbN));

  a_r7_read_release: assert property (@(posedge clk) disable iff (!rstN)
    (!dStrbN && rdWr) |-> !ibOe);

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busReqN |-> (!ibOe && !strbOe && !busyOe));

  a_r10_lock_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busyOe && !busyOut) |-> (lockOe && !lockOut));

endmodule

bind mbus_master mbus_master_chk u_chk (
  .clk(clk), .rstN(rstN), .busReqN(busReqN), .adStrb(adStrb),
  .dStrbN(dStrbN), .strbOe(strbOe), .statOe(statOe), .ibOe(ibOe),
  .busyOut(busyOut), .busyOe(busyOe), .lockOut(lockOut), .lockOe(lockOe),
  .rdWr(rdWr), .done(done)
);

// File: tb/mbus_master_bench.sv
module mbus_master_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, reqValid, reqWrite, reqMem, reqData, reqLock;
  logic [15:0] reqAddr, reqWdata, rdata, ibIn, ibOut;
  logic done, busReqN, busGntN, busyIn, busyOut, busyOe;
  logic lockIn, lockOut, lockOe, adStrb, dStrbN, strbOe;
  logic rdyA, rdyD, ibOe, rdWr, memIo, datInst, statOe;

  mbus_master u_mbus_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMem(reqMem), .reqData(reqData), .reqLock(reqLock),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .done(done), .rdata(rdata),
    .busReqN(busReqN), .busGntN(busGntN), .busyIn(busyIn),
    .busyOut(busyOut), .busyOe(busyOe), .lockIn(lockIn),
    .lockOut(lockOut), .lockOe(lockOe), .adStrb(adStrb), .dStrbN(dStrbN),
    .strbOe(strbOe), .rdyA(rdyA), .rdyD(rdyD), .ibIn(ibIn),
    .ibOut(ibOut), .ibOe(ibOe), .rdWr(rdWr), .memIo(memIo),
    .datInst(datInst), .statOe(statOe)
  );

  int checks = 0;
  int failures = 0;
  logic finished = 1'b0;

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic        mem;
    logic        dat;
    logic [3:0]  aw;
    logic [3:0]  dw;
    logic [15:0] addr;
    logic [15:0] wd;
    logic [15:0] rd;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 4'd0, 4'd0, 16'h1234, 16'h0000, 16'hBEEF},
    '{1'b1, 1'b1, 1'b1, 4'd0, 4'd0, 16'h2000, 16'h5A5A, 16'h0000},
    '{1'b0, 1'b0, 1'b0, 4'd2, 4'd0, 16'h00FF, 16'h0000, 16'h0F0F},
    '{1'b1, 1'b0, 1'b1, 4'd0, 4'd3, 16'h8001, 16'hC3C3, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 4'd3, 4'd2, 16'hFFFF, 16'h0000, 16'h0001},
    '{1'b1, 1'b1, 1'b0, 4'd1, 4'd1, 16'h0000, 16'hFFFF, 16'h0000}
  };

  // One full transfer; grant assumed low, bus free
  task automatic runVec(input vec_t v, input logic lk, input logic expLockFin,
                        output logic sawReq);
    int n = 0, aCnt = 0, dCnt = 0;
    logic started = 1'b0;
    sawReq = 1'b0;
    @(negedge clk);
    reqWrite = v.wr; reqMem = v.mem; reqData = v.dat; reqLock = lk;
    reqAddr = v.addr; reqWdata = v.wd; ibIn = v.rd;
    rdyA = 1'b1; rdyD = 1'b1; reqValid = 1'b1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!busReqN) sawReq = 1'b1;
      if (adStrb) begin
        started = 1'b1;
        n = 1;
        check(ibOe && ibOut == v.addr, "R4 address on bus", {15'd0, ibOe, ibOut}, {16'd1, v.addr});
        check(rdWr == !v.wr && memIo == v.mem && datInst == v.dat && statOe,
              "R8 status", {rdWr, memIo, datInst, statOe}, {!v.wr, v.mem, v.dat, 1'b1});
        check(!lockOut && !busyOut, "R10 lock follows busy", {lockOut, busyOut}, 0);
      end else if (started) begin
        n++;
        if (busyOe && !busyOut && dStrbN) begin
          rdyA = (aCnt >= int'(v.aw));
          aCnt++;
        end
        if (!dStrbN) begin
          rdyD = (dCnt >= int'(v.dw));
          dCnt++;
          if (v.wr) check(ibOe && ibOut == v.wd, "R7 write data", {15'd0, ibOe, ibOut}, {16'd1, v.wd});
          else      check(!ibOe, "R7 read release", ibOe, 0);
        end
        if (done) begin
          check(n == 4 + int'(v.aw) + int'(v.dw), "R3 R5 R6 cycle length", n,
                4 + int'(v.aw) + int'(v.dw));
          if (!v.wr) check(rdata == v.rd, "R7 read data", rdata, v.rd);
          if (expLockFin) check(lockOut == 1'b1, "R10 lock released with busy", lockOut, 1);
          reqValid = 1'b0;
          rdyA = 1'b1; rdyD = 1'b1;
          break;
        end
      end
    end
    if (!started) check(1'b0, "R3 cycle never started", 0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic sawReq;
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqMem = 1'b0;
    reqData = 1'b0; reqLock = 1'b0; reqAddr = '0; reqWdata = '0;
    busGntN = 1'b1; busyIn = 1'b1; lockIn = 1'b1; rdyA = 1'b1; rdyD = 1'b1;
    ibIn = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busReqN && !adStrb && dStrbN && !done, "R1 reset strobes",
          {busReqN, adStrb, dStrbN, done}, 4'b1010);
    check(!ibOe && !strbOe && !statOe && !busyOe && !lockOe, "R1 reset enables",
          {ibOe, strbOe, statOe, busyOe, lockOe}, 0);
    rstN = 1'b1;

    // R2 / R9 arbitration holds
    @(negedge clk);
    reqAddr = 16'hA5A5; reqWrite = 1'b0; reqMem = 1'b1; reqData = 1'b1;
    reqValid = 1'b1;
    @(negedge clk);
    check(!busReqN, "R2 request raised", busReqN, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!busReqN && !adStrb, "R2 grant high holds", {busReqN, adStrb}, 0);
      check(!ibOe && !strbOe && !busyOe, "R9 pads floated", {ibOe, strbOe, busyOe}, 0);
    end
    busGntN = 1'b0; busyIn = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check(!adStrb && !busReqN, "R2 busy holds", {adStrb, busReqN}, 2'b00);
    end
    busyIn = 1'b1; lockIn = 1'b0;
    @(negedge clk);
    check(!adStrb && !busReqN, "R2 lock holds", {adStrb, busReqN}, 2'b00);
    lockIn = 1'b1;
    @(negedge clk);
    check(adStrb && busReqN, "R2 acquire and release request", {adStrb, busReqN}, 2'b11);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) break;
    end
    reqValid = 1'b0;
    @(negedge clk);

    // vector table
    for (int i = 0; i < NV; i++) begin
      runVec(VECS[i], 1'b0, 1'b1, sawReq);
      check(sawReq, "R2 request seen", sawReq, 1);
    end

    // R11 locked read-modify-write pair
    runVec('{1'b0, 1'b1, 1'b1, 4'd1, 4'd0, 16'h0404, 16'h0, 16'h7777}, 1'b1, 1'b0, sawReq);
    @(negedge clk);
    check(lockOe && !lockOut && !busyOe, "R11 lock held while idle",
          {lockOe, lockOut, busyOe}, 3'b100);
    runVec('{1'b1, 1'b1, 1'b1, 4'd0, 4'd1, 16'h0404, 16'h7778, 16'h0}, 1'b0, 1'b0, sawReq);
    check(!sawReq, "R11 no rearbitration", sawReq, 0);
    @(negedge clk);
    check(!lockOe, "R11 lock released", lockOe, 0);

    // R1 reset mid-cycle
    runVec(VECS[0], 1'b0, 1'b1, sawReq);
    @(negedge clk);
    reqAddr = 16'h3333; reqWrite = 1'b1; reqValid = 1'b1;
    repeat (3) @(negedge clk);
    check(busyOe, "R1 cycle in progress", busyOe, 1);
    rstN = 1'b0; reqValid = 1'b0;
    #1;
    check(!ibOe && !strbOe && !busyOe && !lockOe && !statOe && busReqN,
          "R1 reset mid-cycle", {ibOe, strbOe, busyOe, lockOe, statOe, busReqN}, 6'b000001);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule